// File: doc/BRIEF.md
# CC Line Attachment Classifier

This block works out what is attached to each of the two configuration-channel pins of a Type-C port. Each pin gets one result from a fixed set: Open, Ra, Rd, or one of the three current levels a source can advertise to a sink (Default, 1.5 A and 3.0 A). The analog front end is outside the block and appears only as ports. It provides a 2-bit coarse level code for whichever pin is currently switched to the measurement path, and one comparator output. That comparator compares the pin against a threshold DAC, and the block programs that DAC itself.

A measurement starts with a one-cycle `start` request. If the front end is still toggling in search of an attach, both pins are reported Open at once. Otherwise the method depends on the role and the mode:

- **Sink role, or source role with level mode:** the block scans pin 1 and then pin 2 through the measurement switch and decodes the level code with the table for that role.
- **Source role, comparator mode:** the block measures only the pin on which the pull-up settled. It compares against a high threshold first and, if needed, against a low one. It waits a settling time derived from the clock frequency before each compare.

`busy` marks a running sequence. Both results update together with a one-cycle `done` pulse.

Top module: `cc_line_classifier`

## Requirements
- R1: Result encoding is 0 Open, 1 Ra, 2 Rd, 3 sink Default, 4 sink 1.5 A, 5 sink 3.0 A. In sink role the level code decodes as 0 to Open, 1 to Default, 2 to 1.5 A and 3 to 3.0 A.
- R2: In source role with `lvl_mode`=1 the level code decodes as 0 to Ra, 1 or 2 to Rd, and 3 to Open.
- R3: In source comparator mode the block first places threshold 0x26 in `dac_ctrl[7:2]`, with `dac_ctrl[1:0]`=0, for SRC_CYC cycles. A high `comp` on the last of them gives Open, and `done` follows SRC_CYC edges after the edge that samples `start`.
- R4: If that first compare is low, threshold 0x05 is held for another SRC_CYC cycles. Then `comp` high gives Ra and low gives Rd, with `done` 2*SRC_CYC edges after the start edge.
- R5: In comparator mode only the pull-up pin is measured (`pu_sel` bit 0 is pin 1, bit 1 is pin 2, and pin 1 wins if both are set). `meas_sel` selects that pin, and the other pin reads Open. If neither bit is set, both pins read Open with `done` on the start edge.
- R6: While `toggling`=1, a start reports both pins Open with `done` on the start edge, whatever the level code or comparator show. No measurement is made and `dac_ctrl` stays 0.
- R7: A level scan drives `meas_sel`=01 for SCAN_CYC cycles and then 10 for SCAN_CYC cycles, with `done` 2*SCAN_CYC edges after the start edge. When idle, `meas_sel` returns to `host_sel`.
- R8: `busy` is high from the start edge until the edge that raises `done`. `done` is never high together with `busy`, and the results change only with `done`.
- R9: A start request while `busy` is high is ignored. This includes a request sampled on the very edge that ends a sequence.
- R10: SRC_CYC = CLK_KHZ*SETTLE_US/1000, and the settling counter never reaches its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a classification |
| toggling | input | 1 | Attach toggling still running |
| role_src | input | 1 | 1 = pulling up (source), 0 = pulling down (sink) |
| lvl_mode | input | 1 | In source role, 1 = decode level code instead of comparator search |
| pu_sel | input | 2 | Pin on which the pull-up settled (bit 0 pin 1, bit 1 pin 2) |
| host_sel | input | 2 | Measurement switch selection to drive when idle |
| lvl_code | input | 2 | Coarse level code of the selected pin |
| comp | input | 1 | Comparator output, pin above threshold |
| dac_ctrl | output | 8 | Threshold control byte, code in bits 7:2 |
| meas_sel | output | 2 | Measurement switch select (bit 0 pin 1, bit 1 pin 2) |
| cc1_term | output | 3 | Pin 1 result |
| cc2_term | output | 3 | Pin 2 result |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle pulse, results updated |

## Verification
Two events can fall in the same cycle: a new start request and the final compare that ends a sequence. The bench raises `start` so that the edge that samples it is the same edge on which the low-threshold compare completes. It then judges that `done` fires once with the correct result and that `busy` does not rise again afterwards. A second case injects a start in the middle of a sequence and checks that the latency and the result are unchanged.

// File: rtl/cc_cls_pkg.sv
// Shared types and decode tables for the CC line classifier.
// Assumes level codes come from a 2-bit coarse detector on the selected pin.
package cc_cls_pkg;

    typedef enum logic [2:0] {
        TERM_OPEN    = 3'd0,
        TERM_RA      = 3'd1,
        TERM_RD      = 3'd2,
        TERM_SNK_DEF = 3'd3,
        TERM_SNK_1P5 = 3'd4,
        TERM_SNK_3P0 = 3'd5
    } term_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SCAN1,
        SEQ_SCAN2,
        SEQ_THR_HI,
        SEQ_THR_LO
    } seq_e;

    localparam logic [5:0] THR_HIGH = 6'h26;
    localparam logic [5:0] THR_LOW  = 6'h05;

    // Decode a coarse level code; src_tbl picks the pulling-up table.
    function automatic term_e lvl_decode(input logic src_tbl, input logic [1:0] code);
        term_e r;
        if (src_tbl) begin
            case (code)
                2'd0:    r = TERM_RA;
                2'd3:    r = TERM_OPEN;
                default: r = TERM_RD;
            endcase
        end else begin
            case (code)
                2'd1:    r = TERM_SNK_DEF;
                2'd2:    r = TERM_SNK_1P5;
                2'd3:    r = TERM_SNK_3P0;
                default: r = TERM_OPEN;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cc_settle_timer.sv
// Settling-wait counter. Counts cycles from a clear; expired is high in the
// last cycle of a window of `limit` cycles. Assumes limit >= 1.
module cc_settle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Cycle counter, restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + CNT_W'(1);
    end

    assign expired = (cnt == limit - CNT_W'(1));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);

endmodule

// File: rtl/cc_seq_ctrl.sv
// Measurement sequencer: picks the method from role, mode and toggling
// status, drives the DAC and measurement switch, and latches the results.
// Assumes the analog front end settles within the timer windows.
module cc_seq_ctrl
    import cc_cls_pkg::*;
#(
    parameter int SRC_CYC = 12,
    parameter int SCAN_CYC = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             toggling,
    input  logic             role_src,
    input  logic             lvl_mode,
    input  logic [1:0]       pu_sel,
    input  logic [1:0]       host_sel,
    input  logic [1:0]       lvl_code,
    input  logic             comp,
    input  logic             expired,
    output logic             tmr_clr,
    output logic [CNT_W-1:0] limit,
    output logic [7:0]       dac_ctrl,
    output logic [1:0]       meas_sel,
    output logic [2:0]       cc1_term,
    output logic [2:0]       cc2_term,
    output logic             busy,
    output logic             done
);

    seq_e  state;
    logic  pin2_q;
    logic  srcdir_q;
    term_e held1;
    term_e cc1_q, cc2_q;
    logic  done_q;
    term_e thr_res;

    // Result of the comparator step in progress.
    always_comb begin
        if (state == SEQ_THR_HI) thr_res = TERM_OPEN;
        else                     thr_res = comp ? TERM_RA : TERM_RD;
    end

    // Sequencer state, working registers and result latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            pin2_q   <= 1'b0;
            srcdir_q <= 1'b0;
            held1    <= TERM_OPEN;
            cc1_q    <= TERM_OPEN;
            cc2_q    <= TERM_OPEN;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SEQ_IDLE: if (start) begin
                    if (toggling) begin
                        cc1_q  <= TERM_OPEN;
                        cc2_q  <= TERM_OPEN;
                        done_q <= 1'b1;
                    end else if (role_src && !lvl_mode) begin
                        if (pu_sel[0]) begin
                            pin2_q <= 1'b0;
                            state  <= SEQ_THR_HI;
                        end else if (pu_sel[1]) begin
                            pin2_q <= 1'b1;
                            state  <= SEQ_THR_HI;
                        end else begin
                            cc1_q  <= TERM_OPEN;
                            cc2_q  <= TERM_OPEN;
                            done_q <= 1'b1;
                        end
                    end else begin
                        srcdir_q <= role_src;
                        state    <= SEQ_SCAN1;
                    end
                end
                SEQ_SCAN1: if (expired) begin
                    held1 <= lvl_decode(srcdir_q, lvl_code);
                    state <= SEQ_SCAN2;
                end
                SEQ_SCAN2: if (expired) begin
                    cc1_q  <= held1;
                    cc2_q  <= lvl_decode(srcdir_q, lvl_code);
                    done_q <= 1'b1;
                    state  <= SEQ_IDLE;
                end
                SEQ_THR_HI, SEQ_THR_LO: if (expired) begin
                    if (state == SEQ_THR_HI && !comp) begin
                        state <= SEQ_THR_LO;
                    end else begin
                        cc1_q  <= pin2_q ? TERM_OPEN : thr_res;
                        cc2_q  <= pin2_q ? thr_res : TERM_OPEN;
                        done_q <= 1'b1;
                        state  <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Timer restart on entry to every wait window; limit per window kind.
    always_comb begin
        tmr_clr = (state == SEQ_IDLE) || expired;
        limit   = (state == SEQ_SCAN1 || state == SEQ_SCAN2) ? CNT_W'(SCAN_CYC)
                                                             : CNT_W'(SRC_CYC);
    end

    // DAC byte and measurement switch drive.
    always_comb begin
        case (state)
            SEQ_THR_HI: dac_ctrl = {THR_HIGH, 2'b00};
            SEQ_THR_LO: dac_ctrl = {THR_LOW, 2'b00};
            default:    dac_ctrl = 8'h00;
        endcase
        case (state)
            SEQ_SCAN1:              meas_sel = 2'b01;
            SEQ_SCAN2:              meas_sel = 2'b10;
            SEQ_THR_HI, SEQ_THR_LO: meas_sel = pin2_q ? 2'b10 : 2'b01;
            default:                meas_sel = host_sel;
        endcase
    end

    assign busy     = (state != SEQ_IDLE);
    assign done     = done_q;
    assign cc1_term = cc1_q;
    assign cc2_term = cc2_q;

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    hold_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expired) |=> $stable(state));

    // R7
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(meas_sel) == 1));

    // R6
    toggle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(start && toggling && !busy)) |->
        (cc1_term == 3'd0 && cc2_term == 3'd0));

    // R5
    other_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state == SEQ_THR_HI || state == SEQ_THR_LO)) |->
        ($past(pin2_q) ? (cc1_term == 3'd0) : (cc2_term == 3'd0)));

endmodule

// File: rtl/cc_line_classifier.sv
// Top of the CC line classifier: derives the settling window from the clock
// rate and joins the sequencer to its timer. Assumes CLK_KHZ*SETTLE_US >= 1000.
module cc_line_classifier #(
    parameter int CLK_KHZ   = 125000,
    parameter int SETTLE_US = 250,
    parameter int SCAN_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       toggling,
    input  logic       role_src,
    input  logic       lvl_mode,
    input  logic [1:0] pu_sel,
    input  logic [1:0] host_sel,
    input  logic [1:0] lvl_code,
    input  logic       comp,
    output logic [7:0] dac_ctrl,
    output logic [1:0] meas_sel,
    output logic [2:0] cc1_term,
    output logic [2:0] cc2_term,
    output logic       busy,
    output logic       done
);

    localparam int SRC_CYC = CLK_KHZ * SETTLE_US / 1000;
    localparam int MAX_CYC = (SRC_CYC > SCAN_CYC) ? SRC_CYC : SCAN_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_clr;
    logic             expired;
    logic [CNT_W-1:0] limit;

    cc_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (limit),
        .expired (expired)
    );

    cc_seq_ctrl #(
        .SRC_CYC  (SRC_CYC),
        .SCAN_CYC (SCAN_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .toggling (toggling),
        .role_src (role_src),
        .lvl_mode (lvl_mode),
        .pu_sel   (pu_sel),
        .host_sel (host_sel),
        .lvl_code (lvl_code),
        .comp     (comp),
        .expired  (expired),
        .tmr_clr  (tmr_clr),
        .limit    (limit),
        .dac_ctrl (dac_ctrl),
        .meas_sel (meas_sel),
        .cc1_term (cc1_term),
        .cc2_term (cc2_term),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: tb/cc_line_classifier_test.sv
// Bench: sweeps level codes, termination voltages, pins, roles and modes.
module cc_line_classifier_test;

    localparam int CLK_KHZ = 48;
    localparam int SETTLE_US = 250;
    localparam int SCAN = 3;
    localparam int W = CLK_KHZ * SETTLE_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, toggling = 1'b0, role_src = 1'b0, lvl_mode = 1'b0;
    logic [1:0] pu_sel = 2'b00, host_sel = 2'b00;
    logic [1:0] c1 = 2'd0, c2 = 2'd0;
    int v_term = 0;
    logic [1:0] lvl_code;
    logic comp;
    logic [7:0] dac_ctrl;
    logic [1:0] meas_sel;
    logic [2:0] cc1_term, cc2_term;
    logic busy, done;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    assign lvl_code = meas_sel[0] ? c1 : (meas_sel[1] ? c2 : 2'd0);
    assign comp = (v_term > int'(dac_ctrl[7:2]));

    cc_line_classifier #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US), .SCAN_CYC(SCAN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .toggling(toggling),
        .role_src(role_src), .lvl_mode(lvl_mode), .pu_sel(pu_sel),
        .host_sel(host_sel), .lvl_code(lvl_code), .comp(comp),
        .dac_ctrl(dac_ctrl), .meas_sel(meas_sel), .cc1_term(cc1_term),
        .cc2_term(cc2_term), .busy(busy), .done(done));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sink_exp(input int c);
        return (c == 0) ? 0 : c + 2;
    endfunction

    function automatic int srcdir_exp(input int c);
        return (c == 0) ? 1 : ((c == 3) ? 0 : 2);
    endfunction

    // kind: 0 none, 1 level scan, 2 compare pin1, 3 compare pin2
    task automatic run(input int lat, input int e1, input int e2, input int kind,
                       input int inj, input string req);
        int j;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        j = 0;
        while (!done && j < lat + 5) begin
            if (kind == 1)
                chk(meas_sel == ((j < SCAN) ? 2'b01 : 2'b10), "R7 scan select",
                    int'(meas_sel), (j < SCAN) ? 1 : 2);
            if (kind >= 2) begin
                chk(meas_sel == ((kind == 2) ? 2'b01 : 2'b10), "R5 measured pin",
                    int'(meas_sel), kind - 1);
                chk(dac_ctrl == ((j < W) ? 8'h98 : 8'h14), "R3 R4 threshold byte",
                    int'(dac_ctrl), (j < W) ? 152 : 20);
            end
            start = (j == inj);
            @(negedge clk);
            j++;
        end
        start = 1'b0;
        chk(j == lat, {req, " latency"}, j, lat);
        chk(int'(cc1_term) == e1, {req, " pin1"}, int'(cc1_term), e1);
        chk(int'(cc2_term) == e2, {req, " pin2"}, int'(cc2_term), e2);
        chk(!busy, "R8 busy low at done", int'(busy), 0);
        chk(dac_ctrl == 8'h00, "R6 dac idle", int'(dac_ctrl), 0);
        chk(meas_sel == host_sel, "R7 restore select", int'(meas_sel), int'(host_sel));
        if (inj >= 0) begin
            @(negedge clk);
            chk(!busy && !done, "R9 ignored start", int'(busy) + int'(done), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && cc1_term == 0 && cc2_term == 0 && dac_ctrl == 0,
            "R8 reset state", int'(busy) + int'(done) + int'(cc1_term), 0);
        rst_n = 1'b1;

        // R1 sink table over all code pairs
        role_src = 1'b0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                c1 = 2'(a); c2 = 2'(b); host_sel = 2'(b);
                run(2 * SCAN, sink_exp(a), sink_exp(b), 1, -1, "R1 sink decode");
            end

        // R2 source direct table
        role_src = 1'b1; lvl_mode = 1'b1;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                c1 = 2'(a); c2 = 2'(b); host_sel = 2'(a);
                run(2 * SCAN, srcdir_exp(a), srcdir_exp(b), 1, -1, "R2 source level decode");
            end

        // R3 R4 R5 comparator search, both pins, every voltage step
        lvl_mode = 1'b0; host_sel = 2'b00;
        for (int p = 1; p <= 2; p++)
            for (int v = 0; v < 64; v++) begin
                int r;
                pu_sel = 2'(p); v_term = v;
                r = (v > 38) ? 0 : ((v > 5) ? 1 : 2);
                run((v > 38) ? W : 2 * W, (p == 1) ? r : 0, (p == 2) ? r : 0,
                    p + 1, -1, (v > 38) ? "R3 high threshold" : "R4 low threshold");
            end

        // R5 pin 1 priority and no settled pull-up
        pu_sel = 2'b11; v_term = 10;
        run(2 * W, 1, 0, 2, -1, "R5 pin1 priority");
        pu_sel = 2'b00;
        run(0, 0, 0, 0, -1, "R5 no pull-up");

        // R6 toggling overrides both roles
        toggling = 1'b1; pu_sel = 2'b01; v_term = 3;
        run(0, 0, 0, 0, -1, "R6 toggling source");
        role_src = 1'b0; c1 = 2'd3; c2 = 2'd2;
        run(0, 0, 0, 0, -1, "R6 toggling sink");
        toggling = 1'b0;

        // R9 start mid-sequence, and start on the finishing edge
        role_src = 1'b1; pu_sel = 2'b10; v_term = 10;
        run(2 * W, 0, 1, 3, 3, "R9 mid-sequence start");
        v_term = 2;
        run(2 * W, 0, 2, 3, 2 * W - 1, "R9 start on final edge");

        // R10 window length derived from clock rate
        chk(W == 12, "R10 window", W, 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule